// File: doc/BRIEF.md
# Interleaved Two-Bank Burst Read Sequencer

This block is the read side of a word-organised memory split into an even bank and an odd bank. Each bank has its own word counter. A load cycle takes a start address. The lowest address bit picks the bank that answers first. The remaining bits pick the word row. After the load, every read strobe returns the next word in address order, alternating between the banks. Only the counter of the bank just read advances. A burst has no length limit and wraps at the end of the array.

Deselecting the block puts it into standby. The counters and the bank pointer are frozen and the data bus is released. Selecting it again without a load resumes the burst exactly where it stopped. A new load may be issued at any time and discards the previous position. Bank contents sit in plain synthesizable arrays that a simple write port fills before use.

The default row width is kept small (256 rows per bank) so that elaboration stays light. Setting `ROW_W` to 15 gives two banks of 32K words of 16 bits with 15-bit counters.

Top module: `ilv_burst_reader`

## Requirements
- R1: A write with `prog_we_i` high stores `prog_data_i` into bank `prog_addr_i[0]` (0 = even, 1 = odd) at row `prog_addr_i[ROW_W:1]`. That word is later returned by reads of that bank and row.
- R2: A load is a clock edge with `ale_i` high and `cs_n_i` low. If `addr_i[0]` is 0, both counters take `addr_i[ROW_W:1]` and the first counted read returns the even-bank word at that row.
- R3: On a load with `addr_i[0]` = 1, the odd counter takes `addr_i[ROW_W:1]` and the even counter takes that row plus one, modulo the bank depth. The first counted read returns the odd-bank word.
- R4: A counted read is a clock edge where `rd_i` is high, `rd_i` was low at the previous edge, `cs_n_i` is low and `ale_i` is low. It captures the current bank's word at its counter, increments only that bank's counter, and switches to the other bank. The word appears on `data_o` from the following cycle.
- R5: `data_oe_o` rises in the cycle after a counted read. It stays high while `rd_i` stays high and `cs_n_i` stays low. It falls one cycle after either ends. Holding `rd_i` high counts only one read. While `data_oe_o` is low, `data_o` is all zeros.
- R6: While `cs_n_i` is high, strobes and loads are ignored and the counters and bank pointer hold. Returning `cs_n_i` low with `ale_i` low resumes the burst from that state.
- R7: A counter at the last row wraps to row 0 and the burst continues without a gap.
- R8: A load takes priority over a read strobe rising at the same edge. No read is counted, `data_oe_o` is low afterwards, and any burst in progress is discarded.
- R9: While `rst_n` is low, the next state is both counters at 0, the even bank selected and `data_oe_o` low. The first read after reset without a load returns even row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ale_i | input | 1 | Address latch strobe, starts a load cycle |
| cs_n_i | input | 1 | Active-low chip select |
| rd_i | input | 1 | Read strobe; a rising edge counts one linear read |
| addr_i | input | ROW_W+1 | Start address: bit 0 bank, upper bits row |
| prog_we_i | input | 1 | Preload write enable |
| prog_addr_i | input | ROW_W+1 | Preload address: bit 0 bank, upper bits row |
| prog_data_i | input | DATA_W | Preload data word |
| data_o | output | DATA_W | Read data, zero when not enabled |
| data_oe_o | output | 1 | Output enable for the tristate data driver |

## Verification
A load and the rising edge of a read strobe can fall on the same clock edge. Load wins that edge. The bench provokes this by raising `ale_i` and `rd_i` together with chip select low. It then checks that `data_oe_o` stays low while the strobe is held and that the next counted read returns the word for the newly loaded start address rather than the old burst position. Standby is also interleaved at random with strobe and latch pulses. Every subsequent read is compared with a model that freezes its counters while deselected.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    typedef enum logic {
        BANK_EVEN = 1'b0,
        BANK_ODD  = 1'b1
    } bank_e;

    function automatic bank_e other_bank(bank_e b);
        return (b == BANK_EVEN) ? BANK_ODD : BANK_EVEN;
    endfunction

endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
    parameter int ROW_W  = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ROW_W-1:0]  waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ROW_W-1:0]  raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << ROW_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    // preload port, no reset on contents
    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/ilv_seq.sv
module ilv_seq
    import ilv_pkg::*;
#(
    parameter int ROW_W  = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale_i,
    input  logic              cs_n_i,
    input  logic              rd_i,
    input  logic [ROW_W:0]    addr_i,
    input  logic [DATA_W-1:0] even_word_i,
    input  logic [DATA_W-1:0] odd_word_i,
    output logic [ROW_W-1:0]  even_row_o,
    output logic [ROW_W-1:0]  odd_row_o,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe_o
);
    typedef struct packed {
        logic [ROW_W-1:0]  row_even;
        logic [ROW_W-1:0]  row_odd;
        bank_e             sel;
        logic              strobe_prev;
        logic              oe;
        logic [DATA_W-1:0] word;
    } seq_t;

    seq_t cur_q, nxt_d;

    logic             load_d;
    logic             advance_d;
    logic [ROW_W-1:0] start_row_d;

    always_comb begin
        nxt_d             = cur_q;
        nxt_d.strobe_prev = rd_i;
        start_row_d       = addr_i[ROW_W:1];
        load_d            = ale_i && !cs_n_i;
        advance_d         = rd_i && !cur_q.strobe_prev && !cs_n_i && !ale_i;

        if (load_d) begin
            nxt_d.row_odd = start_row_d;
            nxt_d.oe      = 1'b0;
            if (addr_i[0]) begin
                nxt_d.row_even = start_row_d + 1'b1;
                nxt_d.sel      = BANK_ODD;
            end else begin
                nxt_d.row_even = start_row_d;
                nxt_d.sel      = BANK_EVEN;
            end
        end else if (advance_d) begin
            nxt_d.oe  = 1'b1;
            nxt_d.sel = other_bank(cur_q.sel);
            if (cur_q.sel == BANK_EVEN) begin
                nxt_d.word     = even_word_i;
                nxt_d.row_even = cur_q.row_even + 1'b1;
            end else begin
                nxt_d.word    = odd_word_i;
                nxt_d.row_odd = cur_q.row_odd + 1'b1;
            end
        end else begin
            nxt_d.oe = cur_q.oe && rd_i && !cs_n_i;
        end

        if (!rst_n) begin
            nxt_d.row_even    = '0;
            nxt_d.row_odd     = '0;
            nxt_d.sel         = BANK_EVEN;
            nxt_d.oe          = 1'b0;
            nxt_d.word        = '0;
            nxt_d.strobe_prev = rd_i;
        end
    end

    always_ff @(posedge clk) begin
        cur_q <= nxt_d;
    end

    assign even_row_o = cur_q.row_even;
    assign odd_row_o  = cur_q.row_odd;
    assign data_oe_o  = cur_q.oe;
    assign data_o     = cur_q.oe ? cur_q.word : '0;

    p_load_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ale_i && !cs_n_i && !addr_i[0]) |=>
            (cur_q.row_even == $past(addr_i[ROW_W:1]) && cur_q.row_odd == $past(addr_i[ROW_W:1])
             && cur_q.sel == BANK_EVEN));

    p_load_odd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ale_i && !cs_n_i && addr_i[0]) |=>
            (cur_q.row_odd == $past(addr_i[ROW_W:1])
             && cur_q.row_even == ROW_W'(cur_q.row_odd + 1'b1) && cur_q.sel == BANK_ODD));

    p_alternate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        advance_d |=> (cur_q.sel != $past(cur_q.sel)));

    p_one_counter_r4: assert property (@(posedge clk) disable iff (!rst_n)
        advance_d |=> ($countones({cur_q.row_even != $past(cur_q.row_even),
                                   cur_q.row_odd  != $past(cur_q.row_odd)}) == 1));

    p_oe_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe_o |-> ($past(!cs_n_i) && $past(rd_i)));

    p_standby_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_i |=> ($stable(cur_q.row_even) && $stable(cur_q.row_odd) && $stable(cur_q.sel)
                    && !data_oe_o));

    p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (advance_d && cur_q.sel == BANK_EVEN && cur_q.row_even == '1) |=> (cur_q.row_even == '0));

    p_load_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ale_i && !cs_n_i) |=> !data_oe_o);

endmodule

// File: rtl/ilv_burst_reader.sv
module ilv_burst_reader #(
    parameter int ROW_W  = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale_i,
    input  logic              cs_n_i,
    input  logic              rd_i,
    input  logic [ROW_W:0]    addr_i,
    input  logic              prog_we_i,
    input  logic [ROW_W:0]    prog_addr_i,
    input  logic [DATA_W-1:0] prog_data_i,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe_o
);
    localparam int NUM_BANKS = 2;

    logic [ROW_W-1:0]  bank_row  [NUM_BANKS];
    logic [DATA_W-1:0] bank_word [NUM_BANKS];

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        ilv_bank #(
            .ROW_W (ROW_W),
            .DATA_W(DATA_W)
        ) u_bank (
            .clk    (clk),
            .we_i   (prog_we_i && (prog_addr_i[0] == 1'(g))),
            .waddr_i(prog_addr_i[ROW_W:1]),
            .wdata_i(prog_data_i),
            .raddr_i(bank_row[g]),
            .rdata_o(bank_word[g])
        );
    end

    ilv_seq #(
        .ROW_W (ROW_W),
        .DATA_W(DATA_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ale_i      (ale_i),
        .cs_n_i     (cs_n_i),
        .rd_i       (rd_i),
        .addr_i     (addr_i),
        .even_word_i(bank_word[0]),
        .odd_word_i (bank_word[1]),
        .even_row_o (bank_row[0]),
        .odd_row_o  (bank_row[1]),
        .data_o     (data_o),
        .data_oe_o  (data_oe_o)
    );

    p_reset_r9: assert property (@(posedge clk)
        !rst_n |=> (!data_oe_o && data_o == '0));

endmodule

// File: tb/tb_ilv_burst_reader.sv
module tb_ilv_burst_reader;
    localparam int ROW_W  = 8;
    localparam int DATA_W = 16;
    localparam int DEPTH  = 1 << ROW_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ale_i = 1'b0;
    logic              cs_n_i = 1'b1;
    logic              rd_i = 1'b0;
    logic [ROW_W:0]    addr_i = '0;
    logic              prog_we_i = 1'b0;
    logic [ROW_W:0]    prog_addr_i = '0;
    logic [DATA_W-1:0] prog_data_i = '0;
    logic [DATA_W-1:0] data_o;
    logic              data_oe_o;

    int checks = 0;
    int fails  = 0;
    int m_even = 0;
    int m_odd  = 0;
    int m_sel  = 0;

    always #4 clk = ~clk;

    ilv_burst_reader #(.ROW_W(ROW_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n), .ale_i(ale_i), .cs_n_i(cs_n_i), .rd_i(rd_i),
        .addr_i(addr_i), .prog_we_i(prog_we_i), .prog_addr_i(prog_addr_i),
        .prog_data_i(prog_data_i), .data_o(data_o), .data_oe_o(data_oe_o)
    );

    function automatic logic [DATA_W-1:0] word_of(int bank, int row);
        logic [7:0] r = 8'(row);
        return {(bank != 0) ? 4'hA : 4'h5, r[3:0] ^ 4'h6, r};
    endfunction

    task automatic chk(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic model_load(int a);
        int r = (a >> 1) % DEPTH;
        m_odd = r;
        if ((a & 1) != 0) begin
            m_even = (r + 1) % DEPTH;
            m_sel  = 1;
        end else begin
            m_even = r;
            m_sel  = 0;
        end
    endtask

    function automatic logic [DATA_W-1:0] model_next();
        logic [DATA_W-1:0] w;
        if (m_sel == 0) begin
            w = word_of(0, m_even);
            m_even = (m_even + 1) % DEPTH;
            m_sel = 1;
        end else begin
            w = word_of(1, m_odd);
            m_odd = (m_odd + 1) % DEPTH;
            m_sel = 0;
        end
        return w;
    endfunction

    task automatic do_load(int a);
        ale_i = 1'b1; cs_n_i = 1'b0; rd_i = 1'b0; addr_i = (ROW_W+1)'(a);
        step();
        ale_i = 1'b0;
        model_load(a);
    endtask

    task automatic do_read(string tag, int hold);
        logic [DATA_W-1:0] exp;
        cs_n_i = 1'b0; ale_i = 1'b0; rd_i = 1'b1;
        step();
        exp = model_next();
        for (int i = 0; i < hold; i++) begin
            chk({tag, " R4 data"}, data_o, exp);
            chk({tag, " R5 oe high"}, 16'(data_oe_o), 16'd1);
            if (i + 1 < hold) step();
        end
        rd_i = 1'b0;
        step();
        chk({tag, " R5 oe low"}, 16'(data_oe_o), 16'd0);
        chk({tag, " R5 data zero"}, data_o, 16'd0);
    endtask

    task automatic do_standby(int n);
        cs_n_i = 1'b1;
        for (int i = 0; i < n; i++) begin
            rd_i = ~rd_i;
            ale_i = (i % 3 == 1);
            addr_i = (ROW_W+1)'($urandom);
            step();
            chk("R6 standby oe", 16'(data_oe_o), 16'd0);
        end
        ale_i = 1'b0; rd_i = 1'b0;
        step();
        cs_n_i = 1'b0;
        step();
    endtask

    initial begin
        void'($urandom(32'h5EED_1026));
        // preload during reset (R1)
        for (int b = 0; b < 2; b++) begin
            for (int r = 0; r < DEPTH; r++) begin
                @(negedge clk);
                prog_we_i = 1'b1;
                prog_addr_i = (ROW_W+1)'((r << 1) | b);
                prog_data_i = word_of(b, r);
            end
        end
        @(negedge clk);
        prog_we_i = 1'b0;
        step();
        chk("R9 reset oe", 16'(data_oe_o), 16'd0);
        chk("R9 reset data", data_o, 16'd0);
        rst_n = 1'b1;
        cs_n_i = 1'b0;
        step();
        m_even = 0; m_odd = 0; m_sel = 0;
        do_read("R9 first after reset", 1);
        do_read("R1 R4 seq", 1);
        do_read("R4 seq", 1);

        do_load(2 * 5);
        do_read("R2 even start", 1);
        do_read("R2 then odd", 1);
        do_read("R2 then even", 1);

        do_load(2 * 7 + 1);
        do_read("R3 odd start", 1);
        do_read("R3 even plus one", 2);
        do_read("R3 odd next", 1);

        do_load(2 * (DEPTH - 1));
        for (int i = 0; i < 5; i++) do_read("R7 wrap even", 1);
        do_load(2 * (DEPTH - 1) + 1);
        for (int i = 0; i < 5; i++) do_read("R7 wrap odd", 1);

        do_load(2 * 20);
        do_read("R6 before standby", 1);
        do_standby(6);
        do_read("R6 resume", 1);
        do_read("R6 resume next", 1);

        do_read("R5 hold", 4);

        // load and strobe rise on the same edge
        do_read("R8 burst", 1);
        ale_i = 1'b1; cs_n_i = 1'b0; rd_i = 1'b1; addr_i = (ROW_W+1)'(2 * 40 + 1);
        step();
        model_load(2 * 40 + 1);
        chk("R8 no read on load edge", 16'(data_oe_o), 16'd0);
        ale_i = 1'b0;
        step();
        chk("R8 held strobe not counted", 16'(data_oe_o), 16'd0);
        rd_i = 1'b0;
        step();
        do_read("R8 new start", 1);

        for (int it = 0; it < 400; it++) begin
            case ($urandom % 6)
                0: do_load(int'($urandom % (2 * DEPTH)));
                1: do_standby(1 + int'($urandom % 4));
                2: do_read("R4 random hold", 1 + int'($urandom % 3));
                default: do_read("R4 random", 1);
            endcase
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule